// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog timer that escalates through four timeout stages in turn. Each stage has its own timeout and its own enable. Each stage also selects what happens when it expires: a level interrupt, or a pulse on one of three reset outputs (CPU, core or system). When an enabled stage expires, its action fires and the timer moves on to the next enabled stage. After stage 3 it wraps to stage 0. A feed write restarts the timer at stage 0 with the counter cleared.

All configuration sits behind a write key. The control word, the four timeouts and the reset pulse width change only while the protect register holds a fixed 32-bit unlock value. Writing any other value to the protect register locks it again. Feed and interrupt clear are accepted at all times. A boot-arm input, sampled in the first cycle after reset, starts the timer with a single system-reset stage. If boot software neither feeds nor disables the timer in time, the chip is reset.

Software writes go through a simple write-only port: a write strobe, a 4-bit word address and 32 bits of data. The current stage number is brought out so that the surrounding logic can see how far the escalation has progressed.

Top module: `wdt_escalator`

## Requirements
- R1: After reset with boot_arm_i low, all four event outputs are low, stage_o is 0, and nothing fires while the timer is not running.
- R2: The counter is TMO_W (default 32) bits wide. An enabled stage with timeout T expires on the (T+1)th clock edge after it was entered. On expiry the counter clears and the timer moves to the next enabled stage in the order 0,1,2,3,0. A timer with only one enabled stage re-enters that same stage.
- R3: Disabled stages are skipped. If the current stage is disabled, the timer moves to the next enabled stage on the next edge and fires no action. If no stage is enabled, the stage stays where it is.
- R4: The action field of a stage encodes what happens on expiry: 0 sets the interrupt, 1 pulses cpu_rst_o, 2 pulses core_rst_o, 3 pulses sys_rst_o. Exactly one action fires per expiry.
- R5: A reset pulse stays high for PW cycles, where PW is the value at address 6 (bits PW_W-1:0). A PW of 0 behaves as 1. The pulse starts on the edge that registers the expiry.
- R6: irq_o is a level. It rises on the edge after an interrupt-action expiry and stays high, even with the timer stopped, until a write to address 8. If an expiry and a clear fall in the same cycle, the set wins.
- R7: Any write to address 7 (feed) returns the timer to stage 0 with the counter cleared, whether the key is held or not.
- R8: The protect register at address 0 is always writable. Writes to the control word (address 1), to timeout s (address 2+s) and to the pulse width (address 6) take effect only while the protect register holds 32'h6B0A_F1E5. Any other value locks them. The block comes out of reset locked.
- R9: Control word layout: bit 0 = run, bit 1+s = enable of stage s, bits 6+2s:5+2s = action of stage s. With run low the counter and stage are held at 0 and nothing fires.
- R10: If boot_arm_i is high in the first cycle after reset, the timer starts with only stage 0 enabled, action system reset and timeout BOOT_TICKS. sys_rst_o then rises on the (BOOT_TICKS+2)th edge after reset release, unless the timer is fed or disabled first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe |
| cfg_addr_i | input | 4 | Word address of the write |
| cfg_wdata_i | input | 32 | Write data |
| boot_arm_i | input | 1 | Arms the boot timeout when high in the first cycle after reset |
| stage_o | output | 2 | Current stage number |
| irq_o | output | 1 | Level interrupt from an interrupt-action expiry |
| cpu_rst_o | output | 1 | CPU reset pulse |
| core_rst_o | output | 1 | Core reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest cases to reach are the escalation paths that pass through disabled stages and wrap past stage 3. The harder of these starts from a disabled current stage, which costs one silent cycle before counting begins. The stimulus reaches them with random enable masks, including empty and single-stage masks, combined with short random timeouts and random actions. A bench model is stepped every cycle and compared with stage_o and all four event outputs.

Directed cases cover the rest:
- a locked write that must leave the expiry time unchanged, with relocking by a key that differs from the unlock value in only its lowest bit;
- a zero pulse width;
- the boot-arm window, measured from reset release.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned N_STAGE = 4;
  localparam logic [31:0] UNLOCK_KEY = 32'h6B0A_F1E5;

  localparam logic [3:0] ADR_KEY  = 4'd0;
  localparam logic [3:0] ADR_CTRL = 4'd1;
  localparam logic [3:0] ADR_TMO0 = 4'd2;
  localparam logic [3:0] ADR_PW   = 4'd6;
  localparam logic [3:0] ADR_FEED = 4'd7;
  localparam logic [3:0] ADR_CLR  = 4'd8;

  typedef enum logic [1:0] {
    ACT_IRQ  = 2'd0,
    ACT_CPU  = 2'd1,
    ACT_CORE = 2'd2,
    ACT_SYS  = 2'd3
  } wdt_act_e;

  // run at bit 0, enables at [4:1], actions at [12:5]
  typedef struct packed {
    logic [N_STAGE-1:0][1:0] act;
    logic [N_STAGE-1:0]      en;
    logic                    run;
  } wdt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W      = 32,
  parameter int unsigned PW_W       = 8,
  parameter int unsigned BOOT_TICKS = 2000
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [3:0]                       addr_i,
  input  logic [31:0]                      wdata_i,
  input  logic                             boot_arm_i,
  output wdt_ctrl_t                        ctrl_o,
  output logic [N_STAGE-1:0][TMO_W-1:0]    tmo_o,
  output logic [PW_W-1:0]                  pw_o,
  output logic                             key_ok_o,
  output logic                             feed_o,
  output logic                             irq_clr_o
);
  localparam logic [TMO_W-1:0] BOOT_T = TMO_W'(BOOT_TICKS);

  logic [31:0] key_q;
  logic        first_q;
  logic        cfg_wr;

  assign key_ok_o  = (key_q == UNLOCK_KEY);
  assign cfg_wr    = we_i && key_ok_o;
  assign feed_o    = we_i && (addr_i == ADR_FEED);
  assign irq_clr_o = we_i && (addr_i == ADR_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      first_q <= 1'b1;
      ctrl_o  <= '0;
      tmo_o   <= '0;
      pw_o    <= PW_W'(1);
    end else begin
      first_q <= 1'b0;
      if (first_q && boot_arm_i) begin
        ctrl_o.run    <= 1'b1;
        ctrl_o.en     <= N_STAGE'(1);
        ctrl_o.act[0] <= ACT_SYS;
        tmo_o[0]      <= BOOT_T;
      end
      if (we_i && addr_i == ADR_KEY) key_q <= wdata_i;
      if (cfg_wr && addr_i == ADR_CTRL) ctrl_o <= wdt_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (cfg_wr && addr_i == ADR_PW) pw_o <= wdata_i[PW_W-1:0];
      for (int s = 0; s < N_STAGE; s++) begin
        if (cfg_wr && addr_i == ADR_TMO0 + 4'(s)) tmo_o[s] <= wdata_i[TMO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  wdt_ctrl_t                     ctrl_i,
  input  logic [N_STAGE-1:0][TMO_W-1:0] tmo_i,
  input  logic                          feed_i,
  output logic [1:0]                    stage_o,
  output logic [N_STAGE-1:0]            fire_o
);
  logic [1:0]       stg_q, stg_nxt;
  logic [TMO_W-1:0] cnt_q;
  logic             expire;

  // first enabled stage after cur, wrapping; cur itself last
  always_comb begin
    stg_nxt = stg_q;
    for (int i = N_STAGE; i >= 1; i--) begin
      if (ctrl_i.en[2'(stg_q + 2'(i))]) stg_nxt = 2'(stg_q + 2'(i));
    end
  end

  assign expire  = ctrl_i.run && !feed_i && ctrl_i.en[stg_q] && (cnt_q == tmo_i[stg_q]);
  assign fire_o  = expire ? (N_STAGE'(1) << ctrl_i.act[stg_q]) : '0;
  assign stage_o = stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      cnt_q <= '0;
    end else if (feed_i || !ctrl_i.run) begin
      stg_q <= '0;
      cnt_q <= '0;
    end else if (!ctrl_i.en[stg_q] || expire) begin
      stg_q <= stg_nxt;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + TMO_W'(1);
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic [PW_W-1:0] pw_i,
  output logic            pulse_o
);
  logic [PW_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= (pw_i == '0) ? PW_W'(1) : pw_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - PW_W'(1);
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W      = 32,
  parameter int unsigned PW_W       = 8,
  parameter int unsigned BOOT_TICKS = 2000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [3:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        boot_arm_i,
  output logic [1:0]  stage_o,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        core_rst_o,
  output logic        sys_rst_o
);
  wdt_ctrl_t                     ctrl;
  logic [N_STAGE-1:0][TMO_W-1:0] tmo;
  logic [PW_W-1:0]               pw;
  logic                          key_ok, feed, irq_clr, irq_q;
  logic [N_STAGE-1:0]            fire;
  logic [N_STAGE-1:1]            rst_vec;

  wdt_regs #(.TMO_W(TMO_W), .PW_W(PW_W), .BOOT_TICKS(BOOT_TICKS)) i_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .boot_arm_i, .ctrl_o(ctrl), .tmo_o(tmo), .pw_o(pw), .key_ok_o(key_ok),
    .feed_o(feed), .irq_clr_o(irq_clr)
  );

  wdt_core #(.TMO_W(TMO_W)) i_core (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .tmo_i(tmo), .feed_i(feed),
    .stage_o, .fire_o(fire)
  );

  for (genvar k = 1; k < N_STAGE; k++) begin : g_pulse
    wdt_pulse #(.PW_W(PW_W)) i_pulse (
      .clk_i, .rst_ni, .trig_i(fire[k]), .pw_i(pw), .pulse_o(rst_vec[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             irq_q <= 1'b0;
    else if (fire[ACT_IRQ])  irq_q <= 1'b1;
    else if (irq_clr)        irq_q <= 1'b0;
  end

  assign irq_o      = irq_q;
  assign cpu_rst_o  = rst_vec[ACT_CPU];
  assign core_rst_o = rst_vec[ACT_CORE];
  assign sys_rst_o  = rst_vec[ACT_SYS];
endmodule

// File: rtl/wdt_sva.sv
module wdt_sva
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [3:0]         addr_i,
  input logic               key_ok,
  input logic               feed,
  input wdt_ctrl_t          ctrl,
  input logic [TMO_W-1:0]   tmo0,
  input logic [N_STAGE-1:0] fire,
  input logic [1:0]         stage,
  input logic               irq,
  input logic               irq_clr,
  input logic               sys_rst
);
  p_locked_ctrl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !key_ok && addr_i == ADR_CTRL) |=> $stable(ctrl));

  p_locked_tmo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !key_ok && addr_i == ADR_TMO0) |=> $stable(tmo0));

  p_feed_stage0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed |=> (stage == 2'd0));

  p_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |=> (stage == 2'd0));

  p_skip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.run && !feed && ctrl.en != '0 && !ctrl.en[stage]) |=> (stage != $past(stage)));

  p_one_action_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire));

  p_sys_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst) |-> $past(fire[ACT_SYS]));

  p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[ACT_IRQ] |=> irq);

  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !irq_clr) |=> irq);
endmodule

bind wdt_escalator wdt_sva #(.TMO_W(TMO_W)) i_wdt_sva (
  .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .key_ok(key_ok),
  .feed(feed), .ctrl(ctrl), .tmo0(tmo[0]), .fire(fire), .stage(stage_o),
  .irq(irq_o), .irq_clr(irq_clr), .sys_rst(sys_rst_o)
);

// File: tb/test_wdt_escalator.sv
module test_wdt_escalator;
  localparam int CLK_PERIOD = 10;
  localparam int BOOT_TICKS = 40;
  localparam logic [31:0] KEY = 32'h6B0A_F1E5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        boot_arm_i = 1'b0;
  logic [1:0]  stage_o;
  logic        irq_o, cpu_rst_o, core_rst_o, sys_rst_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_escalator #(.TMO_W(32), .PW_W(8), .BOOT_TICKS(BOOT_TICKS)) i_wdt_escalator (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .boot_arm_i,
    .stage_o, .irq_o, .cpu_rst_o, .core_rst_o, .sys_rst_o
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_reset(input logic arm);
    @(negedge clk_i);
    rst_ni = 1'b0; boot_arm_i = arm;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [31:0] ctrl_word(input logic run, input logic [3:0] en, input logic [7:0] acts);
    return {19'd0, acts, en, run};
  endfunction

  function automatic logic rst_of(input int r);
    case (r)
      1: return cpu_rst_o;
      2: return core_rst_o;
      default: return sys_rst_o;
    endcase
  endfunction

  function automatic int nxt(input int s, input logic [3:0] en);
    for (int i = 1; i <= 4; i++) if (en[(s + i) % 4]) return (s + i) % 4;
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int rnd;
    rnd = $urandom(32'd4711);

    // R1: reset state
    do_reset(1'b0);
    tick();
    check(stage_o == 0, "R1", "stage", stage_o, 0);
    check(!irq_o && !cpu_rst_o && !core_rst_o && !sys_rst_o, "R1", "outputs",
          {irq_o, cpu_rst_o, core_rst_o, sys_rst_o}, 0);
    begin
      int seen = 0;
      for (int k = 0; k < BOOT_TICKS + 10; k++) begin
        tick();
        if (sys_rst_o || cpu_rst_o || core_rst_o || irq_o) seen++;
      end
      check(seen == 0, "R10", "no boot reset with arm low", seen, 0);
    end

    // R8: locked write ignored
    wr(4'd1, ctrl_word(1'b1, 4'b0001, 8'h03));
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        tick();
        if (sys_rst_o || stage_o != 0) seen++;
      end
      check(seen == 0, "R8", "locked ctrl write", seen, 0);
    end

    // R2 R5: stage 0 cpu reset, T=10, PW=3
    wr(4'd0, KEY);
    wr(4'd2, 32'd10);
    wr(4'd6, 32'd3);
    wr(4'd1, ctrl_word(1'b1, 4'b0001, 8'h01));
    for (int k = 1; k <= 14; k++) begin
      tick();
      if (k == 10) check(!cpu_rst_o, "R2", "cpu before expiry", cpu_rst_o, 0);
      if (k == 11) check(cpu_rst_o, "R2", "cpu at expiry", cpu_rst_o, 1);
      if (k == 13) check(cpu_rst_o, "R5", "pulse last cycle", cpu_rst_o, 1);
      if (k == 14) check(!cpu_rst_o, "R5", "pulse ended", cpu_rst_o, 0);
    end

    // R8 relock by near key, R7 feed while locked
    wr(4'd0, KEY ^ 32'd1);
    wr(4'd2, 32'd3);
    wr(4'd7, 32'd0);
    for (int k = 1; k <= 11; k++) begin
      tick();
      if (k == 0 || k == 4) check(!cpu_rst_o, "R8", "locked timeout ignored", cpu_rst_o, 0);
      if (k == 10) check(!cpu_rst_o, "R7", "fed: not yet", cpu_rst_o, 0);
      if (k == 11) check(cpu_rst_o, "R7", "fed: expiry", cpu_rst_o, 1);
    end

    // R6 interrupt level and clear
    wr(4'd0, KEY);
    wr(4'd1, 32'd0);
    wr(4'd8, 32'd0);
    repeat (10) tick();
    check(!irq_o && !cpu_rst_o, "R9", "stopped quiet", {irq_o, cpu_rst_o}, 0);
    wr(4'd2, 32'd4);
    wr(4'd1, ctrl_word(1'b1, 4'b0001, 8'h00));
    for (int k = 1; k <= 5; k++) begin
      tick();
      if (k == 4) check(!irq_o, "R6", "irq before expiry", irq_o, 0);
      if (k == 5) check(irq_o, "R4", "irq action", irq_o, 1);
    end
    wr(4'd1, 32'd0);
    repeat (10) tick();
    check(irq_o, "R6", "irq held while stopped", irq_o, 1);
    check(stage_o == 0, "R9", "stage held", stage_o, 0);
    wr(4'd8, 32'd0);
    check(!irq_o, "R6", "irq cleared", irq_o, 0);

    // R5: PW=0 acts as 1
    wr(4'd6, 32'd0);
    wr(4'd2, 32'd2);
    wr(4'd1, ctrl_word(1'b1, 4'b0001, 8'h02));
    for (int k = 1; k <= 4; k++) begin
      tick();
      if (k == 3) check(core_rst_o, "R5", "pw0 core high", core_rst_o, 1);
      if (k == 4) check(!core_rst_o, "R5", "pw0 one cycle", core_rst_o, 0);
    end

    // R2 R3 R4: random escalation against a cycle model
    for (int t = 0; t < 30; t++) begin
      int tmo[4];
      int act[4];
      logic [3:0] en;
      int pw, ms, mc, ev;
      int pc[4];
      logic m_irq;
      logic [7:0] acts;
      wr(4'd0, KEY);
      wr(4'd1, 32'd0);
      wr(4'd8, 32'd0);
      repeat (10) tick();
      for (int s = 0; s < 4; s++) begin
        tmo[s] = $urandom_range(9, 0);
        act[s] = $urandom_range(3, 0);
        wr(4'd2 + 4'(s), 32'(tmo[s]));
      end
      en = (t == 0) ? 4'b0000 : (t == 1) ? 4'b0100 : 4'($urandom_range(15, 0));
      pw = $urandom_range(4, 1);
      wr(4'd6, 32'(pw));
      acts = {2'(act[3]), 2'(act[2]), 2'(act[1]), 2'(act[0])};
      wr(4'd1, ctrl_word(1'b1, en, acts));
      ms = 0; mc = 0; m_irq = 1'b0;
      for (int r = 0; r < 4; r++) pc[r] = 0;
      for (int k = 1; k <= 60; k++) begin
        tick();
        ev = -1;
        if (!en[ms]) begin
          ms = nxt(ms, en); mc = 0;
        end else if (mc == tmo[ms]) begin
          ev = act[ms]; ms = nxt(ms, en); mc = 0;
        end else begin
          mc++;
        end
        for (int r = 1; r < 4; r++) begin
          if (ev == r) pc[r] = pw;
          else if (pc[r] > 0) pc[r]--;
        end
        if (ev == 0) m_irq = 1'b1;
        check(stage_o == 2'(ms), "R3", "stage sequence", stage_o, ms);
        check(irq_o == m_irq, "R4", "irq", irq_o, m_irq);
        for (int r = 1; r < 4; r++)
          check(rst_of(r) == (pc[r] > 0), "R2", "reset output", rst_of(r), pc[r] > 0);
      end
    end

    // R10: boot arm
    do_reset(1'b1);
    for (int k = 1; k <= BOOT_TICKS + 2; k++) begin
      tick();
      if (k == BOOT_TICKS + 1) check(!sys_rst_o, "R10", "boot not yet", sys_rst_o, 0);
      if (k == BOOT_TICKS + 2) check(sys_rst_o, "R10", "boot expiry", sys_rst_o, 1);
    end
    boot_arm_i = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule